// File: doc/BRIEF.md
# SMI Event Enable and Gating Controller

This block collects power-management events and turns them into a single active-low system management interrupt line plus a one-cycle SCI request. Software programs a 32-bit enable register through a small register bus. Each enable bit decides whether its event source may record a cause and raise the interrupt. Some enable bits do more than gate. One starts a countdown timer. One intercepts sleep requests. A write-only bit fires the SCI request. An external lock freezes the TCO enable.

Each recorded cause sits in a status register. Software clears a status bit by writing 1 to it. The interrupt line stays low while any status bit is set.

The sources are:
- a TCO event,
- NMIs rerouted to SMI,
- a legacy USB event,
- a periodic event,
- I/O traps on two microcontroller ports,
- writes to the APM command port,
- sleep-enable writes,
- the software SMI timer.

Register map:
- Address 0 is the enable register.
- Address 1 is the status register.
- Reads are combinational.
- Writes take effect at the next clock edge.

Top module: `smi_gate_ctrl`

## Requirements
- R1: After reset, both registers read 0, `smi_n` is 1, and `sci_pulse` and `slp_req` are 0.
- R2: Enable bits 6..0 read back as written. Bits 31..7 of the enable register always read 0, and bit 7 is write-only.
- R3: While `tco_lock` is 1, a write to the enable register leaves bit 0 (TCO enable) unchanged. The other bits still update.
- R4: A `tco_evt` pulse sets status bit 0 only if enable bit 0 is set. An `nmi_evt` pulse while `nmi_reroute_en` is 1 sets status bit 0 even when enable bit 0 is 0.
- R5: Writing 1 to enable bit 7 makes `sci_pulse` high for exactly the one cycle after the write edge. Writing 0 there does nothing.
- R6: After enable bit 6 is written to 1, status bit 6 becomes set exactly P clocks after the write edge. P is 16 when `tmr_rate_sel` is 0 and 64 when it is 1. Enable bit 6 stays set afterwards.
- R7: Clearing enable bit 6 before expiry restarts the count, and status bit 6 is never set.
- R8: A pulse on `apm_cnt_wr` sets status bit 4 only if enable bit 4 is set.
- R9: A `slp_en_wr` pulse with enable bit 5 set sets status bit 5 and raises no `slp_req`. With enable bit 5 clear, it raises `slp_req` for one cycle and sets no status.
- R10: With enable bit 3 set, an `io_acc_valid` access to port 0x62 or 0x66 sets status bit 3. Accesses to any other port do not set it.
- R11: `usb_evt` sets status bit 1 and `periodic_evt` sets status bit 2, each only if the matching enable bit is set.
- R12: `smi_n` is 0 whenever any status bit is set. Writing 1s to address 1 clears those status bits. A set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 is enable, 1 is status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| tco_lock | input | 1 | Freezes the TCO enable bit |
| tco_evt | input | 1 | TCO event pulse |
| nmi_evt | input | 1 | NMI event pulse |
| nmi_reroute_en | input | 1 | Routes NMI events to SMI regardless of the TCO enable |
| usb_evt | input | 1 | Legacy USB event pulse |
| periodic_evt | input | 1 | Periodic event pulse |
| io_acc_valid | input | 1 | An I/O access is presented |
| io_acc_port | input | 16 | I/O port address of the access |
| apm_cnt_wr | input | 1 | Write to the APM command port |
| slp_en_wr | input | 1 | Software wrote 1 to the sleep-enable bit |
| tmr_rate_sel | input | 1 | Software timer period select (0: 16, 1: 64 clocks) |
| smi_n | output | 1 | Active-low SMI |
| sci_pulse | output | 1 | One-cycle SCI request |
| slp_req | output | 1 | Forwarded sleep request pulse |

## Verification
Each gated source is pulsed twice: once with its enable clear and once with it set. This tells a true gate apart from a source that always records, or one that never does. The NMI reroute is pulsed with the TCO enable clear, to show that the reroute bypasses the gate. The lock is tried with writes of both polarities, so that a frozen bit is distinguished from a bit that happens to hold the written value.

The timer is run at both rates and sampled one cycle before and at the expected expiry. This separates an exact period from an off-by-one. A run cancelled mid-count shows that the count restarts rather than pauses. The trap is tried on both trapped ports and on a neighbouring port, and a set is made to collide with a clear to show which one wins.

// File: rtl/smi_gate_pkg.sv
package smi_gate_pkg;
  localparam int unsigned NUM_SRC     = 7;
  localparam int unsigned B_TCO       = 0;
  localparam int unsigned B_USB       = 1;
  localparam int unsigned B_PER       = 2;
  localparam int unsigned B_MCTRAP    = 3;
  localparam int unsigned B_APM       = 4;
  localparam int unsigned B_SLEEP     = 5;
  localparam int unsigned B_SWTMR     = 6;
  localparam int unsigned B_RELEASE   = 7;
  localparam logic        ADDR_ENABLE = 1'b0;
  localparam logic        ADDR_STATUS = 1'b1;
endpackage

// File: rtl/smi_enable_reg.sv
module smi_enable_reg
  import smi_gate_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NUM_SRC:0]   wdata,
  input  logic               tco_lock,
  output logic [NUM_SRC-1:0] en_q,
  output logic               rel_pulse
);
  logic [NUM_SRC-1:0] en_d;
  logic               rel_d;

  always_comb begin
    en_d  = en_q;
    rel_d = 1'b0;
    if (wr_en) begin
      en_d = wdata[NUM_SRC-1:0];
      if (tco_lock) en_d[B_TCO] = en_q[B_TCO];
      rel_d = wdata[B_RELEASE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      rel_pulse <= 1'b0;
    end else begin
      en_q      <= en_d;
      rel_pulse <= rel_d;
    end
  end
endmodule

// File: rtl/smi_swtimer.sv
module smi_swtimer #(
  parameter int unsigned FAST_CYC = 16,
  parameter int unsigned SLOW_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic rate_sel,
  output logic expire
);
  localparam int unsigned MAX_CYC = (FAST_CYC > SLOW_CYC) ? FAST_CYC : SLOW_CYC;
  localparam int unsigned CNT_W   = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_CYC - 1);
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, last;

  assign last   = rate_sel ? SLOW_LAST : FAST_LAST;
  assign expire = run && (cnt_q == last);

  always_comb begin
    if (!run || expire) cnt_d = '0;
    else                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/smi_status_bank.sv
module smi_status_bank
  import smi_gate_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_vec,
  input  logic [NUM_SRC-1:0] clr_vec,
  output logic [NUM_SRC-1:0] sts_q
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    logic d;
    assign d = set_vec[i] | (sts_q[i] & ~clr_vec[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_q[i] <= 1'b0;
      else        sts_q[i] <= d;
    end
  end
endmodule

// File: rtl/smi_gate_ctrl.sv
module smi_gate_ctrl
  import smi_gate_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned PORT_W    = 16,
  parameter int unsigned TMR_FAST  = 16,
  parameter int unsigned TMR_SLOW  = 64,
  parameter int unsigned MC_PORT_A = 16'h0062,
  parameter int unsigned MC_PORT_B = 16'h0066
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tco_lock,
  input  logic              tco_evt,
  input  logic              nmi_evt,
  input  logic              nmi_reroute_en,
  input  logic              usb_evt,
  input  logic              periodic_evt,
  input  logic              io_acc_valid,
  input  logic [PORT_W-1:0] io_acc_port,
  input  logic              apm_cnt_wr,
  input  logic              slp_en_wr,
  input  logic              tmr_rate_sel,
  output logic              smi_n,
  output logic              sci_pulse,
  output logic              slp_req
);
  localparam int unsigned PAD_W = DATA_W - NUM_SRC;

  logic               rst_meta_n, rst_sync_n;
  logic [NUM_SRC-1:0] en_q, sts_q, set_vec, clr_vec;
  logic               wr_enable, wr_status, tmr_expire, mc_hit, slp_req_d;
  logic               unused_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign wr_enable    = bus_we && (bus_addr == ADDR_ENABLE);
  assign wr_status    = bus_we && (bus_addr == ADDR_STATUS);
  assign unused_wdata = ^bus_wdata[DATA_W-1:NUM_SRC+1];

  smi_enable_reg u_en (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_enable),
    .wdata    (bus_wdata[NUM_SRC:0]),
    .tco_lock (tco_lock),
    .en_q     (en_q),
    .rel_pulse(sci_pulse)
  );

  smi_swtimer #(.FAST_CYC(TMR_FAST), .SLOW_CYC(TMR_SLOW)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (en_q[B_SWTMR]),
    .rate_sel(tmr_rate_sel),
    .expire  (tmr_expire)
  );

  assign mc_hit = io_acc_valid &&
                  ((io_acc_port == PORT_W'(MC_PORT_A)) || (io_acc_port == PORT_W'(MC_PORT_B)));

  always_comb begin
    set_vec           = '0;
    set_vec[B_TCO]    = (tco_evt & en_q[B_TCO]) | (nmi_evt & nmi_reroute_en);
    set_vec[B_USB]    = usb_evt & en_q[B_USB];
    set_vec[B_PER]    = periodic_evt & en_q[B_PER];
    set_vec[B_MCTRAP] = mc_hit & en_q[B_MCTRAP];
    set_vec[B_APM]    = apm_cnt_wr & en_q[B_APM];
    set_vec[B_SLEEP]  = slp_en_wr & en_q[B_SLEEP];
    set_vec[B_SWTMR]  = tmr_expire;
    clr_vec           = wr_status ? bus_wdata[NUM_SRC-1:0] : '0;
  end

  smi_status_bank u_sts (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_vec(set_vec),
    .clr_vec(clr_vec),
    .sts_q  (sts_q)
  );

  assign slp_req_d = slp_en_wr & ~en_q[B_SLEEP];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) slp_req <= 1'b0;
    else             slp_req <= slp_req_d;
  end

  assign smi_n     = ~(|sts_q);
  assign bus_rdata = (bus_addr == ADDR_ENABLE) ? {{PAD_W{1'b0}}, en_q}
                                               : {{PAD_W{1'b0}}, sts_q};
endmodule

// File: rtl/smi_gate_chk.sv
module smi_gate_chk
  import smi_gate_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               bus_we,
  input logic               bus_addr,
  input logic               rel_bit,
  input logic [31:7]        rd_hi,
  input logic               tco_lock,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] sts_q,
  input logic               sci_pulse,
  input logic               slp_en_wr,
  input logic               slp_req,
  input logic               apm_cnt_wr,
  input logic               smi_n
);
  AST_ENABLE_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_ENABLE) |-> (rd_hi == '0)); // R2

  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (tco_lock && bus_we && bus_addr == ADDR_ENABLE) |=> $stable(en_q[B_TCO])); // R3

  AST_SCI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    sci_pulse |-> $past(bus_we && bus_addr == ADDR_ENABLE && rel_bit)); // R5

  AST_TMR_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[B_SWTMR] |=> !$rose(sts_q[B_SWTMR])); // R7

  AST_APM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_cnt_wr && !en_q[B_APM]) |=> !$rose(sts_q[B_APM])); // R8

  AST_SLEEP_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (slp_en_wr && en_q[B_SLEEP]) |=> !slp_req); // R9

  AST_SMI_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q == '0) |-> smi_n); // R12
endmodule

bind smi_gate_ctrl smi_gate_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .rel_bit   (bus_wdata[7]),
  .rd_hi     (bus_rdata[31:7]),
  .tco_lock  (tco_lock),
  .en_q      (en_q),
  .sts_q     (sts_q),
  .sci_pulse (sci_pulse),
  .slp_en_wr (slp_en_wr),
  .slp_req   (slp_req),
  .apm_cnt_wr(apm_cnt_wr),
  .smi_n     (smi_n)
);

// File: tb/smi_gate_ctrl_tb_top.sv
`timescale 1ns/100ps
module smi_gate_ctrl_tb_top;
  typedef struct {
    int          kind;   // 0 rdata, 1 smi_n, 2 sci_pulse, 3 slp_req
    logic [31:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0, bus_addr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tco_lock = 0, tco_evt = 0, nmi_evt = 0, nmi_reroute_en = 0;
  logic        usb_evt = 0, periodic_evt = 0, io_acc_valid = 0;
  logic [15:0] io_acc_port = '0;
  logic        apm_cnt_wr = 0, slp_en_wr = 0, tmr_rate_sel = 0;
  logic        smi_n, sci_pulse, slp_req;

  item_t q[$];
  int    n_run = 0, n_fail = 0;
  bit    done = 0;

  always #2.5 clk = ~clk;

  smi_gate_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tco_lock(tco_lock),
    .tco_evt(tco_evt), .nmi_evt(nmi_evt), .nmi_reroute_en(nmi_reroute_en),
    .usb_evt(usb_evt), .periodic_evt(periodic_evt), .io_acc_valid(io_acc_valid),
    .io_acc_port(io_acc_port), .apm_cnt_wr(apm_cnt_wr), .slp_en_wr(slp_en_wr),
    .tmr_rate_sel(tmr_rate_sel), .smi_n(smi_n), .sci_pulse(sci_pulse),
    .slp_req(slp_req)
  );

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0:       act = bus_rdata;
        1:       act = {31'd0, smi_n};
        2:       act = {31'd0, sci_pulse};
        default: act = {31'd0, slp_req};
      endcase
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic expect_item(input int kind, input logic [31:0] val, input string req);
    item_t it;
    it.kind = kind; it.exp = val; it.req = req;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic exp_rd(input logic a, input logic [31:0] val, input string req);
    bus_addr = a;
    expect_item(0, val, req);
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    step();
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic clear_all();
    wr(1'b1, 32'hFFFF_FFFF);
    wr(1'b0, 32'h0);
  endtask

  task automatic timer_run(input logic rate, input int per, input string req);
    tmr_rate_sel = rate;
    wr(1'b0, 32'h40);
    repeat (per - 1) step();
    exp_rd(1'b1, 32'h0, req);
    step();
    exp_rd(1'b1, 32'h40, req);
    exp_rd(1'b0, 32'h40, req);
    expect_item(1, 32'd0, req);
    clear_all();
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state
    exp_rd(1'b0, 32'h0, "R1");
    exp_rd(1'b1, 32'h0, "R1");
    expect_item(1, 32'd1, "R1");
    expect_item(2, 32'd0, "R1");
    expect_item(3, 32'd0, "R1");

    // R2 readback, upper bits zero, bit 7 write-only
    wr(1'b0, 32'hFFFF_FF3E);
    exp_rd(1'b0, 32'h0000_003E, "R2");
    wr(1'b0, 32'h0);
    exp_rd(1'b0, 32'h0, "R2");

    // R3 lock freezes TCO enable, both polarities
    tco_lock = 1'b1;
    wr(1'b0, 32'h01);
    exp_rd(1'b0, 32'h00, "R3");
    tco_lock = 1'b0;
    wr(1'b0, 32'h01);
    tco_lock = 1'b1;
    wr(1'b0, 32'h02);
    exp_rd(1'b0, 32'h03, "R3");
    tco_lock = 1'b0;
    wr(1'b0, 32'h0);

    // R4 TCO gating and NMI reroute
    tco_evt = 1; step(); tco_evt = 0;
    exp_rd(1'b1, 32'h0, "R4");
    wr(1'b0, 32'h01);
    tco_evt = 1; step(); tco_evt = 0;
    exp_rd(1'b1, 32'h01, "R4");
    clear_all();
    nmi_reroute_en = 1; nmi_evt = 1; step(); nmi_evt = 0; nmi_reroute_en = 0;
    exp_rd(1'b1, 32'h01, "R4");
    clear_all();

    // R5 release bit
    wr(1'b0, 32'h80);
    expect_item(2, 32'd1, "R5");
    exp_rd(1'b0, 32'h0, "R5");
    step();
    expect_item(2, 32'd0, "R5");
    wr(1'b0, 32'h00);
    expect_item(2, 32'd0, "R5");

    // R6 timer, both rates
    timer_run(1'b0, 16, "R6");
    timer_run(1'b1, 64, "R6");

    // R7 cancel before expiry, then full fresh period
    tmr_rate_sel = 0;
    wr(1'b0, 32'h40);
    repeat (10) step();
    wr(1'b0, 32'h00);
    repeat (40) step();
    exp_rd(1'b1, 32'h0, "R7");
    timer_run(1'b0, 16, "R7");

    // R8 APM gating
    apm_cnt_wr = 1; step(); apm_cnt_wr = 0;
    exp_rd(1'b1, 32'h0, "R8");
    wr(1'b0, 32'h10);
    apm_cnt_wr = 1; step(); apm_cnt_wr = 0;
    exp_rd(1'b1, 32'h10, "R8");
    clear_all();

    // R9 sleep intercept
    slp_en_wr = 1; step(); slp_en_wr = 0;
    expect_item(3, 32'd1, "R9");
    exp_rd(1'b1, 32'h0, "R9");
    step();
    expect_item(3, 32'd0, "R9");
    wr(1'b0, 32'h20);
    slp_en_wr = 1; step(); slp_en_wr = 0;
    expect_item(3, 32'd0, "R9");
    exp_rd(1'b1, 32'h20, "R9");
    clear_all();

    // R10 microcontroller port trap
    wr(1'b0, 32'h08);
    io_acc_valid = 1; io_acc_port = 16'h0064; step(); io_acc_valid = 0;
    exp_rd(1'b1, 32'h0, "R10");
    io_acc_valid = 1; io_acc_port = 16'h0062; step(); io_acc_valid = 0;
    exp_rd(1'b1, 32'h08, "R10");
    wr(1'b1, 32'h08);
    io_acc_valid = 1; io_acc_port = 16'h0066; step(); io_acc_valid = 0;
    exp_rd(1'b1, 32'h08, "R10");
    clear_all();
    wr(1'b0, 32'h0);
    io_acc_valid = 1; io_acc_port = 16'h0062; step(); io_acc_valid = 0;
    exp_rd(1'b1, 32'h0, "R10");

    // R11 USB and periodic gating
    usb_evt = 1; periodic_evt = 1; step(); usb_evt = 0; periodic_evt = 0;
    exp_rd(1'b1, 32'h0, "R11");
    wr(1'b0, 32'h04);
    usb_evt = 1; periodic_evt = 1; step(); usb_evt = 0; periodic_evt = 0;
    exp_rd(1'b1, 32'h04, "R11");
    wr(1'b0, 32'h06);
    usb_evt = 1; step(); usb_evt = 0;
    exp_rd(1'b1, 32'h06, "R11");

    // R12 partial clear keeps SMI low, full clear releases, set wins
    expect_item(1, 32'd0, "R12");
    wr(1'b1, 32'h02);
    exp_rd(1'b1, 32'h04, "R12");
    expect_item(1, 32'd0, "R12");
    wr(1'b1, 32'h04);
    expect_item(1, 32'd1, "R12");
    bus_addr = 1'b1; bus_wdata = 32'h02; bus_we = 1'b1; usb_evt = 1'b1;
    step();
    bus_we = 1'b0; usb_evt = 1'b0; bus_wdata = '0;
    exp_rd(1'b1, 32'h02, "R12");
    expect_item(1, 32'd0, "R12");
    clear_all();
    expect_item(1, 32'd1, "R12");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule